// File: doc/BRIEF.md
# Event Status Bank with Maskable Interrupt

This block is the status bank a host reads to learn what a packet controller has seen. It has eight bit positions, and a per-position build-time constant gives each one of two behaviours. A latched position records one-cycle event pulses and keeps them until the host writes a one to clear it. A real-time position shows the live condition input at the moment it is read, keeps no history, and ignores writes.

An interrupt-enable register has one bit per position and can be read and written. It decides which latched events may pull the shared interrupt output low. That output is active low and registered, so it never glitches. It stays low as long as an enabled latched bit is set. It goes high again when the host has cleared every enabled latched event, or has disabled it.

Access goes through a simple port: address, write strobe, write data and combinational read data. The event pulses and condition levels arrive on two input vectors of the same width as the bank.

Top module: `event_status_bank`

## Requirements
- R1: While reset is held and just after it is released, every latched status bit reads 0, the enable register (address 1) reads 0, and `irq_n` is 1.
- R2: An event pulse on a latched position (bit i of `LATCH_MAP` is 1; the default 8'hC7 makes bits 0, 1, 2, 6 and 7 latched) sets that status bit on the next clock edge. The bit stays 1 after the pulse ends.
- R3: A write to the status register (address 0) clears each latched bit whose data bit is 1. Latched bits whose data bit is 0 are left unchanged.
- R4: After a latched bit has been cleared, it stays 0 until a new event pulse arrives on that position.
- R5: At a real-time position (bit i of `LATCH_MAP` is 0; bits 3, 4 and 5 by default), reading address 0 returns the present `cond` bit in the same cycle. Event pulses and writes at that position have no effect, and nothing is remembered once `cond` falls.
- R6: If an event pulse and a write-one clear hit the same latched bit in the same cycle, the bit ends up set.
- R7: The enable register at address 1 stores all eight written bits and reads them back.
- R8: `irq_n` goes to 0 on the clock edge after any latched status bit and its enable bit are both 1. It goes back to 1 on the edge after no such pair remains.
- R9: A latched event whose enable bit is 0 leaves `irq_n` at 1. Enable bits at real-time positions never pull `irq_n` low, whatever `cond` is.
- R10: Addresses 2 and 3 read as 0. Writes to them change neither the status bits nor the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 2 | Register address: 0 = status, 1 = interrupt enable |
| wdata | input | 8 | Write data; for the status register, ones select the latched bits to clear |
| rdata | output | 8 | Read data for `addr`, combinational |
| evt | input | 8 | One-cycle event pulses, one per position |
| cond | input | 8 | Live condition levels, one per position |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
The bench targets the cycle in which a clear and a new event meet. A design that let the clear win would lose that event, and the status read afterwards would show 0. It also writes a pattern of ones and zeros to the status register. A design that treated the write as a plain store, or that cleared real-time positions, would show wrong bits or lose the live condition. The interrupt is sampled one cycle after the enable changes, when it must still be high, and again one cycle later, when it must be low. This catches an unregistered path, a design that ignores the enable, and one that lets real-time positions or writes to unused addresses reach the interrupt or the registers.

// File: rtl/sbank_pkg.sv
package sbank_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_EN   = 2'd1
  } reg_sel_e;
endpackage

// File: rtl/sbank_rst_sync.sv
module sbank_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/sbank_status.sv
module sbank_status #(
  parameter int unsigned W         = 8,
  parameter logic [W-1:0] LATCH_MAP = 8'hC7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] cond,
  input  logic         clr_stb,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] view
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LATCH_MAP[i]) begin : g_latched
      logic bit_q, bit_d, bit_ce;

      always_comb begin
        bit_ce = evt[i] | (clr_stb & clr_bits[i]);
        bit_d  = bit_q;
        if (clr_stb && clr_bits[i]) bit_d = 1'b0;
        if (evt[i])                 bit_d = 1'b1;   // set beats clear
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (bit_ce) bit_q <= bit_d;
      end

      assign stat_q[i] = bit_q;
      assign view[i]   = bit_q;
    end else begin : g_live
      assign stat_q[i] = 1'b0;
      assign view[i]   = cond[i];
    end
  end
endmodule

// File: rtl/sbank_en_reg.sv
module sbank_en_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  logic [W-1:0] en_d;

  always_comb en_d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (we) en_q <= en_d;
  end
endmodule

// File: rtl/sbank_irq.sv
module sbank_irq #(
  parameter int unsigned W         = 8,
  parameter logic [W-1:0] LATCH_MAP = 8'hC7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat,
  input  logic [W-1:0] en,
  output logic         irq_n
);
  logic irq_n_d;

  always_comb irq_n_d = ~|(stat & en & LATCH_MAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= irq_n_d;
  end
endmodule

// File: rtl/event_status_bank.sv
module event_status_bank
  import sbank_pkg::*;
#(
  parameter int unsigned  W         = 8,
  parameter logic [W-1:0] LATCH_MAP = 8'hC7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      evt,
  input  logic [W-1:0]      cond,
  output logic              irq_n
);
  logic         rst_n_s;
  logic         wr_stat, wr_en_reg;
  logic [W-1:0] stat_q, stat_view, en_q;

  sbank_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_n_s)
  );

  always_comb begin
    wr_stat   = wr_en && (addr == REG_STAT);
    wr_en_reg = wr_en && (addr == REG_EN);
  end

  sbank_status #(.W(W), .LATCH_MAP(LATCH_MAP)) u_stat (
    .clk(clk), .rst_n(rst_n_s), .evt(evt), .cond(cond),
    .clr_stb(wr_stat), .clr_bits(wdata), .stat_q(stat_q), .view(stat_view)
  );

  sbank_en_reg #(.W(W)) u_en (
    .clk(clk), .rst_n(rst_n_s), .we(wr_en_reg), .wdata(wdata), .en_q(en_q)
  );

  sbank_irq #(.W(W), .LATCH_MAP(LATCH_MAP)) u_irq (
    .clk(clk), .rst_n(rst_n_s), .stat(stat_q), .en(en_q), .irq_n(irq_n)
  );

  always_comb begin
    case (addr)
      REG_STAT: rdata = stat_view;
      REG_EN:   rdata = en_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/event_status_bank_chk.sv
module event_status_bank_chk #(
  parameter int unsigned  W         = 8,
  parameter logic [W-1:0] LATCH_MAP = 8'hC7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic [W-1:0] evt,
  input logic [W-1:0] cond,
  input logic [W-1:0] stat,
  input logic [W-1:0] en,
  input logic         irq_n
);
  // R2 / R6: a latched event is present on the next cycle, even under a clear
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & LATCH_MAP)) |=> ((stat & $past(evt & LATCH_MAP)) == $past(evt & LATCH_MAP)));

  // R3: a write-one clear without a coincident event leaves the bit at 0
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> ((stat & $past(wdata & ~evt)) == '0));

  // R4: no status bit rises without an event
  p_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat & ~$past(stat) & ~$past(evt)) == '0));

  // R5: real-time positions read the live condition
  p_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> ((rdata & ~LATCH_MAP) == (cond & ~LATCH_MAP)));

  // R7: enable register takes the written value
  p_en_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> (en == $past(wdata)));

  // R8 / R9: registered interrupt follows enabled latched status
  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_n == !$past(|(stat & en & LATCH_MAP))));

  // R10: unused addresses read zero
  p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1]) |-> (rdata == '0));
endmodule

bind event_status_bank event_status_bank_chk #(.W(W), .LATCH_MAP(LATCH_MAP)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .evt(evt), .cond(cond), .stat(stat_q), .en(en_q), .irq_n(irq_n)
);

// File: tb/sim_event_status_bank.sv
module sim_event_status_bank;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, evt, cond;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  event_status_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt(evt), .cond(cond), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; evt = '0; cond = '0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {7'd0, irq_n}, 8'h01);
    rd("R1 status in reset", 2'd0, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd("R1 status after reset", 2'd0, 8'h00);
    rd("R1 enable after reset", 2'd1, 8'h00);
    check("R1 irq after reset", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_set_hold;
    pulse(8'h05);
    rd("R2 set", 2'd0, 8'h05);
    repeat (3) @(negedge clk);
    rd("R2 hold", 2'd0, 8'h05);
    pulse(8'h08);
    rd("R5 event on live bit ignored", 2'd0, 8'h05);
  endtask

  task automatic t_clear;
    wr(2'd0, 8'h01);
    rd("R3 clear one bit", 2'd0, 8'h04);
    wr(2'd0, 8'h00);
    rd("R3 write zero keeps", 2'd0, 8'h04);
    wr(2'd0, 8'hFF);
    rd("R3 clear all", 2'd0, 8'h00);
  endtask

  task automatic t_rearm;
    repeat (3) @(negedge clk);
    rd("R4 stays clear", 2'd0, 8'h00);
    pulse(8'h80);
    rd("R4 new event sets", 2'd0, 8'h80);
    wr(2'd0, 8'h80);
    rd("R4 cleared again", 2'd0, 8'h00);
  endtask

  task automatic t_live;
    @(negedge clk); cond = 8'h38;
    rd("R5 live read", 2'd0, 8'h38);
    cond = 8'hFF;
    rd("R5 only live positions", 2'd0, 8'h38);
    wr(2'd0, 8'hFF);
    rd("R5 write ignored", 2'd0, 8'h38);
    cond = 8'h00;
    rd("R5 no history", 2'd0, 8'h00);
  endtask

  task automatic t_collide;
    pulse(8'h02);
    rd("R6 pre-set", 2'd0, 8'h02);
    @(negedge clk); evt = 8'h02; wr_en = 1'b1; addr = 2'd0; wdata = 8'h02;
    @(negedge clk); evt = '0; wr_en = 1'b0; wdata = '0;
    rd("R6 set wins", 2'd0, 8'h02);
    @(negedge clk); evt = 8'h40; wr_en = 1'b1; addr = 2'd0; wdata = 8'h02;
    @(negedge clk); evt = '0; wr_en = 1'b0; wdata = '0;
    rd("R6 other bit cleared, new set", 2'd0, 8'h40);
    wr(2'd0, 8'hFF);
    rd("R6 cleanup", 2'd0, 8'h00);
  endtask

  task automatic t_enable;
    wr(2'd1, 8'hA5);
    rd("R7 readback", 2'd1, 8'hA5);
    wr(2'd1, 8'h5A);
    rd("R7 readback 2", 2'd1, 8'h5A);
    wr(2'd1, 8'h00);
    rd("R7 zero", 2'd1, 8'h00);
  endtask

  task automatic t_irq;
    pulse(8'h01);
    @(negedge clk);
    check("R9 masked event", {7'd0, irq_n}, 8'h01);
    @(negedge clk); wr_en = 1'b1; addr = 2'd1; wdata = 8'h01;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    check("R8 registered delay", {7'd0, irq_n}, 8'h01);
    @(negedge clk);
    check("R8 assert", {7'd0, irq_n}, 8'h00);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 8'h01;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    check("R8 still low one cycle", {7'd0, irq_n}, 8'h00);
    @(negedge clk);
    check("R8 release", {7'd0, irq_n}, 8'h01);
    wr(2'd1, 8'h38);
    cond = 8'h38;
    repeat (3) @(negedge clk);
    check("R9 live bits no irq", {7'd0, irq_n}, 8'h01);
    cond = 8'h00;
    wr(2'd1, 8'h00);
  endtask

  task automatic t_unused;
    pulse(8'h40);
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd("R10 addr2 zero", 2'd2, 8'h00);
    rd("R10 addr3 zero", 2'd3, 8'h00);
    rd("R10 status untouched", 2'd0, 8'h40);
    rd("R10 enable untouched", 2'd1, 8'h3C);
  endtask

  initial begin
    t_reset;
    t_set_hold;
    t_clear;
    t_rearm;
    t_live;
    t_collide;
    t_enable;
    t_irq;
    t_unused;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule